// File: doc/BRIEF.md
# Paravirtual I/O Device Register Front-End

This block is the memory-mapped register window of a paravirtual I/O device that uses the legacy register arrangement. A host bus master issues single read or write requests, each with a byte offset and an access size. The block decodes each request, updates or returns the addressed register, and answers one cycle later with read data and error and warning flags. It holds the feature word written by the guest, one address word per queue, the queue selector, the last notified queue index, the device status byte and a pending-interrupt flag. The device feature word comes from the backend as an input.

Queue address and queue size are banked. Both registers show the queue named by the selector. Queue sizes are fixed per queue and computed from a parameter. A backend kick pulse sets the pending flag, and that flag drives the interrupt line. Reading the interrupt status byte returns the flag and clears it. Offsets from the device-specific base up to the end of the mapped region go to a separate configuration port, with the offset rebased to zero. The region length is a fixed base plus a parameterised configuration size.

Top module: `vio_regfront`

## Requirements
- R1: After reset, irq is 0, and reads of guest features, queue select, queue notify, device status and queue address (queue 0) all return 0.
- R2: Offset 0x00 is a read-only 4-byte word that returns dev_features. A correctly sized write there changes nothing, sets rsp_warn and does not set rsp_err.
- R3: Offset 0x04 is a 4-byte read/write guest feature word, and its value is visible on guest_features.
- R4: Offset 0x08 is a 4-byte read/write queue address for the queue that the selector currently names. When the selector is at or above NQ, writes there are dropped and reads return 0.
- R5: Offset 0x0C is a 2-byte read-only queue size. It equals QBASE >> q for a selected queue q below NQ, and 0 otherwise. Any correctly sized write to it sets rsp_err.
- R6: Offset 0x0E is a 2-byte read/write queue selector.
- R7: A 2-byte write to offset 0x10 stores the value and raises notify_valid for exactly one cycle in the response cycle, with notify_queue equal to the written value. A read returns the last value written.
- R8: Offset 0x12 is a 1-byte read/write device status, and its value is visible on dev_status.
- R9: Offset 0x13 is a 1-byte interrupt status. A read returns 1 if an interrupt is pending and 0 if not, then clears the flag, so irq is 0 in the next cycle. A write there changes nothing and sets rsp_warn.
- R10: A kick pulse sets the pending flag, so irq is 1 in the next cycle. A kick in the same cycle as an interrupt status read leaves the flag set.
- R11: An offset in [0x14, 0x14+CFG_BYTES) asserts cfg_valid in the same cycle, with cfg_offset = offset - 0x14 and the request's write, size and data passed through. A read there returns the cfg_rdata present in the request cycle. No size check is made on these offsets.
- R12: An unmapped offset (including any at or beyond 0x14+CFG_BYTES), or a size that differs from the register width, sets rsp_err and leaves all state unchanged.
- R13: Every request gets rsp_valid one cycle later. req_size gives the byte count (1, 2 or 4). Read data is right-aligned and zero-extended, and writes use the low bytes of req_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset inside the region |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| dev_features | input | 32 | Feature word offered by the backend |
| kick | input | 1 | Backend interrupt request pulse |
| cfg_rdata | input | 32 | Read data from the configuration port |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Request was illegal |
| rsp_warn | output | 1 | Write to a read-only word was ignored |
| cfg_valid | output | 1 | Configuration port request |
| cfg_write | output | 1 | Configuration port direction |
| cfg_offset | output | AW | Rebased configuration offset |
| cfg_size | output | 3 | Configuration access size |
| cfg_wdata | output | 32 | Configuration write data |
| irq | output | 1 | Interrupt line |
| notify_valid | output | 1 | Queue notify pulse |
| notify_queue | output | 16 | Notified queue index |
| guest_features | output | 32 | Stored guest feature word |
| dev_status | output | 8 | Stored device status |

## Verification
Directed sequences come first. They cover reset values, read-only writes, queue banking with selector values inside and outside the queue range, the full interrupt sequence of kick, read, re-read and a kick at the same moment as a read, and forwarding at the first offset, last offset and one past the last. These separate a missing clear from a clear that wins over a kick, and a correct rebase from an off-by-base offset. A seeded random mix then interleaves reads, writes, kicks, wrong sizes and configuration-window accesses against a bench model. This exposes state that leaks across queues or updates on an errored request.

// File: rtl/vio_pkg.sv
package vio_pkg;

    localparam int OFF_DEV_FEAT   = 'h00;
    localparam int OFF_GUEST_FEAT = 'h04;
    localparam int OFF_Q_ADDR     = 'h08;
    localparam int OFF_Q_SIZE     = 'h0C;
    localparam int OFF_Q_SEL      = 'h0E;
    localparam int OFF_Q_NOTIFY   = 'h10;
    localparam int OFF_STATUS     = 'h12;
    localparam int OFF_ISR        = 'h13;
    localparam int OFF_DEV_BASE   = 'h14;

    typedef enum logic [3:0] {
        SEL_DEV_FEAT,
        SEL_GUEST_FEAT,
        SEL_Q_ADDR,
        SEL_Q_SIZE,
        SEL_Q_SEL,
        SEL_Q_NOTIFY,
        SEL_STATUS,
        SEL_ISR,
        SEL_CFG,
        SEL_NONE
    } vio_sel_e;

    // Width in bytes that each fixed register accepts
    function automatic logic [2:0] sel_bytes(vio_sel_e s);
        case (s)
            SEL_DEV_FEAT, SEL_GUEST_FEAT, SEL_Q_ADDR: return 3'd4;
            SEL_Q_SIZE, SEL_Q_SEL, SEL_Q_NOTIFY:      return 3'd2;
            SEL_STATUS, SEL_ISR:                      return 3'd1;
            default:                                  return 3'd0;
        endcase
    endfunction

    typedef struct packed {
        logic [31:0] gfeat;
        logic [15:0] qsel;
        logic [15:0] notify;
        logic [7:0]  status;
        logic        pend;
        logic        rsp_valid;
        logic [31:0] rsp_data;
        logic        rsp_err;
        logic        rsp_warn;
        logic        ntf_valid;
    } vio_state_t;

endpackage

// File: rtl/vio_decode.sv
module vio_decode
    import vio_pkg::*;
#(
    parameter int AW        = 8,
    parameter int CFG_BYTES = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    size,
    output vio_sel_e      sel,
    output logic          size_ok,
    output logic [AW-1:0] cfg_off
);
    localparam int LIMIT = OFF_DEV_BASE + CFG_BYTES;

    logic [31:0] addr_w;
    assign addr_w = 32'(addr);

    always_comb begin
        sel = SEL_NONE;
        if (addr_w >= 32'(OFF_DEV_BASE) && addr_w < 32'(LIMIT)) begin
            sel = SEL_CFG;
        end else begin
            case (addr_w)
                32'(OFF_DEV_FEAT):   sel = SEL_DEV_FEAT;
                32'(OFF_GUEST_FEAT): sel = SEL_GUEST_FEAT;
                32'(OFF_Q_ADDR):     sel = SEL_Q_ADDR;
                32'(OFF_Q_SIZE):     sel = SEL_Q_SIZE;
                32'(OFF_Q_SEL):      sel = SEL_Q_SEL;
                32'(OFF_Q_NOTIFY):   sel = SEL_Q_NOTIFY;
                32'(OFF_STATUS):     sel = SEL_STATUS;
                32'(OFF_ISR):        sel = SEL_ISR;
                default:             sel = SEL_NONE;
            endcase
        end
        size_ok = (sel == SEL_CFG) || (sel != SEL_NONE && size == sel_bytes(sel));
        cfg_off = addr - AW'(OFF_DEV_BASE);
    end

endmodule

// File: rtl/vio_qbank.sv
module vio_qbank #(
    parameter int NQ    = 4,
    parameter int QBASE = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] qsel,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rd_addr,
    output logic [15:0] rd_size
);
    logic [31:0] qa_q [NQ];

    genvar g;
    generate
        for (g = 0; g < NQ; g++) begin : g_queue
            logic        hit;
            logic [31:0] qa_d;
            always_comb begin
                hit  = (qsel == 16'(g));
                qa_d = (wr_en && hit) ? wdata : qa_q[g];
            end
            always_ff @(posedge clk) begin
                if (!rst_n) qa_q[g] <= '0;
                else        qa_q[g] <= qa_d;
            end
        end
    endgenerate

    always_comb begin
        rd_addr = '0;
        rd_size = '0;
        for (int i = 0; i < NQ; i++) begin
            if (qsel == 16'(i)) begin
                rd_addr = qa_q[i];
                rd_size = 16'(QBASE >> i);
            end
        end
    end

endmodule

// File: rtl/vio_regfront.sv
module vio_regfront
    import vio_pkg::*;
#(
    parameter int AW        = 8,
    parameter int CFG_BYTES = 32,
    parameter int NQ        = 4,
    parameter int QBASE     = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [31:0]   req_wdata,
    input  logic [31:0]   dev_features,
    input  logic          kick,
    input  logic [31:0]   cfg_rdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_err,
    output logic          rsp_warn,
    output logic          cfg_valid,
    output logic          cfg_write,
    output logic [AW-1:0] cfg_offset,
    output logic [2:0]    cfg_size,
    output logic [31:0]   cfg_wdata,
    output logic          irq,
    output logic          notify_valid,
    output logic [15:0]   notify_queue,
    output logic [31:0]   guest_features,
    output logic [7:0]    dev_status
);
    vio_state_t    st_q, st_d;
    vio_sel_e      sel;
    logic          size_ok;
    logic [AW-1:0] cfg_off;
    logic          qa_wr;
    logic [31:0]   qa_rd;
    logic [15:0]   qs_rd;
    logic          isr_clr;

    vio_decode #(.AW(AW), .CFG_BYTES(CFG_BYTES)) dec_i (
        .addr    (req_addr),
        .size    (req_size),
        .sel     (sel),
        .size_ok (size_ok),
        .cfg_off (cfg_off)
    );

    vio_qbank #(.NQ(NQ), .QBASE(QBASE)) qbank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .qsel    (st_q.qsel),
        .wr_en   (qa_wr),
        .wdata   (req_wdata),
        .rd_addr (qa_rd),
        .rd_size (qs_rd)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_data  = '0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_warn  = 1'b0;
        st_d.ntf_valid = 1'b0;
        qa_wr          = 1'b0;
        isr_clr        = 1'b0;

        if (req_valid) begin
            if (!size_ok) begin
                st_d.rsp_err = 1'b1;
            end else begin
                case (sel)
                    SEL_DEV_FEAT: begin
                        if (req_write) st_d.rsp_warn = 1'b1;
                        else           st_d.rsp_data = dev_features;
                    end
                    SEL_GUEST_FEAT: begin
                        if (req_write) st_d.gfeat    = req_wdata;
                        else           st_d.rsp_data = st_q.gfeat;
                    end
                    SEL_Q_ADDR: begin
                        if (req_write) qa_wr         = 1'b1;
                        else           st_d.rsp_data = qa_rd;
                    end
                    SEL_Q_SIZE: begin
                        if (req_write) st_d.rsp_err  = 1'b1;
                        else           st_d.rsp_data = 32'(qs_rd);
                    end
                    SEL_Q_SEL: begin
                        if (req_write) st_d.qsel     = req_wdata[15:0];
                        else           st_d.rsp_data = 32'(st_q.qsel);
                    end
                    SEL_Q_NOTIFY: begin
                        if (req_write) begin
                            st_d.notify    = req_wdata[15:0];
                            st_d.ntf_valid = 1'b1;
                        end else begin
                            st_d.rsp_data  = 32'(st_q.notify);
                        end
                    end
                    SEL_STATUS: begin
                        if (req_write) st_d.status   = req_wdata[7:0];
                        else           st_d.rsp_data = 32'(st_q.status);
                    end
                    SEL_ISR: begin
                        if (req_write) begin
                            st_d.rsp_warn = 1'b1;
                        end else begin
                            st_d.rsp_data = 32'(st_q.pend);
                            isr_clr       = 1'b1;
                        end
                    end
                    SEL_CFG: begin
                        if (!req_write) st_d.rsp_data = cfg_rdata;
                    end
                    default: st_d.rsp_err = 1'b1;
                endcase
            end
        end

        st_d.pend = (st_q.pend & ~isr_clr) | kick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_valid      = req_valid && (sel == SEL_CFG);
    assign cfg_write      = req_write;
    assign cfg_offset     = cfg_off;
    assign cfg_size       = req_size;
    assign cfg_wdata      = req_wdata;

    assign rsp_valid      = st_q.rsp_valid;
    assign rsp_rdata      = st_q.rsp_data;
    assign rsp_err        = st_q.rsp_err;
    assign rsp_warn       = st_q.rsp_warn;
    assign irq            = st_q.pend;
    assign notify_valid   = st_q.ntf_valid;
    assign notify_queue   = st_q.notify;
    assign guest_features = st_q.gfeat;
    assign dev_status     = st_q.status;

endmodule

// File: rtl/vio_regfront_chk.sv
module vio_regfront_chk #(
    parameter int AW        = 8,
    parameter int CFG_BYTES = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic          kick,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic          rsp_warn,
    input logic          cfg_valid,
    input logic [AW-1:0] cfg_offset,
    input logic          irq,
    input logic          notify_valid
);
    a_r10_kick_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> irq);

    a_r10_irq_rise_needs_kick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(kick));

    a_r9_irq_fall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(req_valid && !req_write && 32'(req_addr) == 32'h13));

    a_r7_notify_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> $past(req_valid && req_write));

    a_r11_cfg_offset_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (32'(cfg_offset) < 32'(CFG_BYTES)));

    a_r13_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    a_r12_err_warn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_err && rsp_warn));

endmodule

bind vio_regfront vio_regfront_chk #(.AW(AW), .CFG_BYTES(CFG_BYTES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .kick         (kick),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_warn     (rsp_warn),
    .cfg_valid    (cfg_valid),
    .cfg_offset   (cfg_offset),
    .irq          (irq),
    .notify_valid (notify_valid)
);

// File: tb/vio_regfront_tb.sv
module vio_regfront_tb_top;
    localparam int AW = 8, CFG_BYTES = 32, NQ = 4, QBASE = 256;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, kick = 0;
    logic [AW-1:0] req_addr = 0;
    logic [2:0] req_size = 0;
    logic [31:0] req_wdata = 0, dev_features = 32'hA5C3_1E0F, cfg_rdata;
    logic rsp_valid, rsp_err, rsp_warn, cfg_valid, cfg_write, irq, notify_valid;
    logic [31:0] rsp_rdata, cfg_wdata, guest_features;
    logic [AW-1:0] cfg_offset;
    logic [2:0] cfg_size;
    logic [15:0] notify_queue;
    logic [7:0] dev_status;

    always #2 clk = ~clk;
    assign cfg_rdata = 32'hC0DE_0000 | 32'(cfg_offset);

    vio_regfront #(.AW(AW), .CFG_BYTES(CFG_BYTES), .NQ(NQ), .QBASE(QBASE)) dut_i (.*);

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    // observed response
    logic [31:0] o_data; logic o_err, o_warn, o_ntf, o_irq, o_cv;
    logic [15:0] o_nq; logic [AW-1:0] o_coff;

    // bench model
    logic [31:0] m_gf, m_qa [NQ];
    logic [15:0] m_sel, m_ntf;
    logic [7:0]  m_st;
    logic        m_pend;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, input logic kk);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd; kick = kk;
        #1; o_cv = cfg_valid; o_coff = cfg_offset;
        @(negedge clk);
        req_valid = 0; kick = 0;
        o_data = rsp_rdata; o_err = rsp_err; o_warn = rsp_warn;
        o_ntf = notify_valid; o_nq = notify_queue; o_irq = irq;
    endtask

    function automatic logic [2:0] width_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h08: return 3'd4;
            8'h0C, 8'h0E, 8'h10: return 3'd2;
            8'h12, 8'h13:        return 3'd1;
            default:             return 3'd0;
        endcase
    endfunction

    function automatic bit in_cfg(input logic [7:0] a);
        return a >= 8'h14 && 32'(a) < 32'h14 + CFG_BYTES;
    endfunction

    function automatic bit exp_err(input logic w, input logic [7:0] a, input logic [2:0] sz);
        if (in_cfg(a)) return 0;
        if (width_of(a) == 0 || width_of(a) != sz) return 1;
        return w && a == 8'h0C;
    endfunction

    function automatic bit exp_warn(input logic w, input logic [7:0] a, input logic [2:0] sz);
        return w && !exp_err(w, a, sz) && (a == 8'h00 || a == 8'h13);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (in_cfg(a)) return 32'hC0DE_0000 | 32'(a - 8'h14);
        case (a)
            8'h00: return dev_features;
            8'h04: return m_gf;
            8'h08: return (m_sel < NQ) ? m_qa[m_sel[1:0]] : 32'h0;
            8'h0C: return (m_sel < NQ) ? 32'(QBASE >> m_sel) : 32'h0;
            8'h0E: return 32'(m_sel);
            8'h10: return 32'(m_ntf);
            8'h12: return 32'(m_st);
            8'h13: return 32'(m_pend);
            default: return 32'h0;
        endcase
    endfunction

    // one access checked against and applied to the model
    task automatic op(input string req, input logic w, input logic [7:0] a, input logic [2:0] sz,
                      input logic [31:0] wd, input logic kk);
        logic e, wn; logic [31:0] rd; bit clr;
        e = exp_err(w, a, sz); wn = exp_warn(w, a, sz);
        rd = (w || e) ? 32'h0 : exp_rd(a);
        clr = !w && !e && a == 8'h13;
        access(w, a, sz, wd, kk);
        chk({req, " err"}, 32'(o_err), 32'(e));
        chk({req, " warn"}, 32'(o_warn), 32'(wn));
        chk({req, " data"}, o_data, rd);
        chk({req, " notify"}, 32'(o_ntf), 32'(w && !e && a == 8'h10));
        if (w && !e) begin
            case (a)
                8'h04: m_gf = wd;
                8'h08: if (m_sel < NQ) m_qa[m_sel[1:0]] = wd;
                8'h0E: m_sel = wd[15:0];
                8'h10: m_ntf = wd[15:0];
                8'h12: m_st = wd[7:0];
                default: ;
            endcase
        end
        m_pend = (m_pend && !clr) || kk;
        chk({req, " irq"}, 32'(o_irq), 32'(m_pend));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_gf = 0; m_sel = 0; m_ntf = 0; m_st = 0; m_pend = 0;
        for (int i = 0; i < NQ; i++) m_qa[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        op("R1 gfeat", 0, 8'h04, 4, 0, 0);
        op("R1 qsel", 0, 8'h0E, 2, 0, 0);
        op("R1 notify", 0, 8'h10, 2, 0, 0);
        op("R1 status", 0, 8'h12, 1, 0, 0);
        op("R1 qaddr", 0, 8'h08, 4, 0, 0);
        // R2 device features
        op("R2 read", 0, 8'h00, 4, 0, 0);
        op("R2 write", 1, 8'h00, 4, 32'hFFFF_FFFF, 0);
        op("R2 reread", 0, 8'h00, 4, 0, 0);
        // R3 guest features
        op("R3 write", 1, 8'h04, 4, 32'h1234_5678, 0);
        chk("R3 port", guest_features, 32'h1234_5678);
        op("R3 read", 0, 8'h04, 4, 0, 0);
        // R4/R6 banking
        op("R4 q0 write", 1, 8'h08, 4, 32'hAAAA_0000, 0);
        op("R6 sel2", 1, 8'h0E, 2, 2, 0);
        op("R6 sel read", 0, 8'h0E, 2, 0, 0);
        op("R4 q2 write", 1, 8'h08, 4, 32'hBBBB_0002, 0);
        op("R4 q2 read", 0, 8'h08, 4, 0, 0);
        op("R5 q2 size", 0, 8'h0C, 2, 0, 0);
        op("R6 sel0", 1, 8'h0E, 2, 0, 0);
        op("R4 q0 read", 0, 8'h08, 4, 0, 0);
        op("R6 sel7", 1, 8'h0E, 2, 7, 0);
        op("R4 oob write", 1, 8'h08, 4, 32'hDEAD_BEEF, 0);
        op("R4 oob read", 0, 8'h08, 4, 0, 0);
        op("R5 oob size", 0, 8'h0C, 2, 0, 0);
        op("R5 size write", 1, 8'h0C, 2, 5, 0);
        // R7 notify
        op("R7 write", 1, 8'h10, 2, 16'h0003, 0);
        chk("R7 queue", 32'(o_nq), 3);
        op("R7 read", 0, 8'h10, 2, 0, 0);
        // R8 status
        op("R8 write", 1, 8'h12, 1, 8'h0F, 0);
        chk("R8 port", 32'(dev_status), 32'h0F);
        op("R8 read", 0, 8'h12, 1, 0, 0);
        // R9/R10 interrupt
        op("R10 kick", 0, 8'h12, 1, 0, 1);
        op("R9 isr read pending", 0, 8'h13, 1, 0, 0);
        op("R9 isr read idle", 0, 8'h13, 1, 0, 0);
        op("R9 isr write", 1, 8'h13, 1, 1, 0);
        op("R10 kick with read", 0, 8'h13, 1, 0, 1);
        op("R10 kick with read2", 0, 8'h13, 1, 0, 1);
        op("R9 final clear", 0, 8'h13, 1, 0, 0);
        // R11 forwarding
        op("R11 first", 0, 8'h14, 4, 0, 0);
        chk("R11 cfg_valid", 32'(o_cv), 1);
        chk("R11 cfg_offset", 32'(o_coff), 0);
        op("R11 mid", 0, 8'h20, 1, 0, 0);
        chk("R11 cfg_offset mid", 32'(o_coff), 32'h0C);
        op("R11 last", 1, 8'h33, 2, 32'h55, 0);
        chk("R11 cfg_valid last", 32'(o_cv), 1);
        // R12 errors
        op("R12 past region", 0, 8'h34, 4, 0, 0);
        chk("R12 no cfg_valid", 32'(o_cv), 0);
        op("R12 unmapped", 1, 8'h01, 1, 0, 0);
        op("R12 wrong size", 1, 8'h04, 2, 32'h9999, 0);
        op("R12 gfeat intact", 0, 8'h04, 4, 0, 0);

        // R13 random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a; logic [2:0] sz; logic w; logic [31:0] wd; int k;
            k = int'($urandom % 10);
            case (k)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                4: a = 8'h0E; 5: a = 8'h10; 6: a = 8'h12; 7: a = 8'h13;
                8: a = 8'h14 + 8'($urandom % CFG_BYTES);
                default: a = 8'($urandom % 64);
            endcase
            sz = width_of(a);
            if (sz == 0 || ($urandom % 8) == 0) sz = 3'($urandom % 5);
            w = ($urandom % 2) == 1;
            if (a == 8'h0C && w && ($urandom % 4) != 0) w = 0;
            wd = $urandom;
            if (a == 8'h0E) wd = $urandom % 6;
            op("R13 random", w, a, sz, wd, ($urandom % 6) == 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule